// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits at the front of an Ethernet receive path and decides whether an incoming frame should be kept, using only the 48-bit destination address at its start. The receive logic asserts a start-of-frame pulse and then presents the frame one byte per valid cycle. While the six address bytes go by, the filter does three things at once:

- it compares them with a programmed station address;
- it notes whether they form the broadcast address or a multicast address;
- it runs a CRC-32 over them to find a bit in a 64-entry multicast hash table.

One clock after the sixth byte, the filter raises a decision strobe together with an accept flag. Both hold until the next start of frame.

Software programs the filter through a simple write port. There is a mode word with a promiscuous bit and a broadcast-reject bit. The station address is spread over two words. The hash table takes two further words. Frame storage and checking of the frame's own CRC belong to other blocks.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the decision strobe and accept flag are low, and all configuration is zero. With zero configuration, broadcast is allowed and the hash table is empty, so a multicast frame is rejected.
- R2: The station address is held in two words. The word at offset 0x40 holds wire bytes 2, 3, 4 and 5 in bits 31:24, 23:16, 15:8 and 7:0. The word at offset 0x44 holds wire byte 0 in bits 15:8 and wire byte 1 in bits 7:0. Wire byte 0 is the first byte received. A destination equal to this address is accepted.
- R3: The all-ones destination is broadcast. It is accepted while bit 3 of the mode word (offset 0x00) is clear, and rejected while that bit is set, unless promiscuous mode is on.
- R4: While bit 5 of the mode word is set (promiscuous), every frame is accepted.
- R5: A destination is multicast when bit 0 of wire byte 0 is 1. A multicast destination that is not broadcast is accepted exactly when its hash bit is set. The hash index is bits 31:26 of a CRC-32 over the six bytes, computed as follows: polynomial 0x04C11DB7, shifted MSB-first, seeded with all ones, each byte fed LSB first, and no final inversion. Index bit 5 picks the word: 0 selects offset 0x48 and 1 selects offset 0x4C. Index bits 4:0 pick the bit within that word.
- R6: With both hash words all ones, every multicast destination is accepted. Broadcast never uses the hash table: it is accepted with an empty table and rejected when bit 3 is set, even with a full table.
- R7: A unicast destination (bit 0 of byte 0 clear) that differs from the station address is rejected when promiscuous mode is off.
- R8: The decision strobe and accept flag change one clock after the sixth address byte is presented, not earlier. They then hold, and any further bytes before the next start of frame are ignored.
- R9: A start-of-frame pulse clears the decision strobe on the next clock and restarts the byte count. A byte presented in the same cycle as the pulse is taken as wire byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ofs | input | 8 | Configuration word offset |
| cfg_wdata | input | 32 | Configuration write data |
| rx_sof | input | 1 | Start-of-frame pulse |
| rx_vld | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte, wire order |
| flt_vld | output | 1 | Decision available |
| flt_accept | output | 1 | Frame accepted (meaningful while flt_vld is high) |

## Verification
A table of destinations is run through one fixed configuration, and each result is compared with a reference model built from the requirements. The table covers:
- the station address, and a station address off by one bit in its last byte, which shows that all 48 bits are compared;
- broadcast, and a unicast address that matches none of the rules;
- a multicast address whose hash bit is set, and others whose bits are not, which separates the hash path from the station path.

Directed tests then cover the remaining cases:
- the mode bits are toggled to separate promiscuous acceptance from broadcast rejection;
- the hash bit is placed in the wrong word to show that index bit 5 selects the word;
- a full table is paired with broadcast rejection to show that broadcast bypasses the hash;
- the strobe is probed just before and just after the sixth byte, and trailing bytes and a start-of-frame that carries a byte are applied to fix the timing.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int          OFS_W    = 8,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_LEN = 6,
  parameter logic [31:0] CRC_POLY = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [OFS_W-1:0]  cfg_ofs,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              rx_sof,
  input  logic              rx_vld,
  input  logic [7:0]        rx_byte,
  output logic              flt_vld,
  output logic              flt_accept
);

  localparam int CNT_W = $clog2(ADDR_LEN + 1);
  localparam logic [OFS_W-1:0] OFS_MODE = OFS_W'(8'h00);
  localparam logic [OFS_W-1:0] OFS_STA0 = OFS_W'(8'h40);
  localparam logic [OFS_W-1:0] OFS_STA1 = OFS_W'(8'h44);
  localparam logic [OFS_W-1:0] OFS_HSH0 = OFS_W'(8'h48);
  localparam logic [OFS_W-1:0] OFS_HSH1 = OFS_W'(8'h4C);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_LEN - 1);
  localparam logic [CNT_W-1:0] DONE_IDX = CNT_W'(ADDR_LEN);

  logic [31:0]      sta_lo;
  logic [15:0]      sta_hi;
  logic [63:0]      hash_tbl;
  logic             rej_bc;
  logic             promisc;

  logic [CNT_W-1:0] cnt;
  logic [31:0]      crc;
  logic             sta_eq;
  logic             all_ff;
  logic             mcast;

  logic [CNT_W-1:0] cnt_cur;
  logic [31:0]      crc_cur;
  logic             eq_cur, ff_cur;
  logic             take, last;
  logic [31:0]      crc_nxt;
  logic [47:0]      station;
  logic [7:0]       sta_byte;
  logic             eq_nxt, ff_nxt, mc_nxt;
  logic [5:0]       hidx;
  logic             verdict;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      logic fb;
      fb = r[31] ^ d[b];
      r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction

  assign station  = {sta_hi, sta_lo};
  assign cnt_cur  = rx_sof ? '0 : cnt;
  assign crc_cur  = rx_sof ? '1 : crc;
  assign eq_cur   = rx_sof ? 1'b1 : sta_eq;
  assign ff_cur   = rx_sof ? 1'b1 : all_ff;
  assign take     = rx_vld && (cnt_cur < DONE_IDX);
  assign last     = take && (cnt_cur == LAST_IDX);
  assign crc_nxt  = crc_step(crc_cur, rx_byte);
  assign sta_byte = station[8*(ADDR_LEN-1-int'(cnt_cur)) +: 8];
  assign eq_nxt   = eq_cur && (rx_byte == sta_byte);
  assign ff_nxt   = ff_cur && (rx_byte == 8'hFF);
  assign mc_nxt   = (cnt_cur == '0) ? rx_byte[0] : mcast;
  assign hidx     = crc_nxt[31:26];
  assign verdict  = promisc | eq_nxt | (ff_nxt & ~rej_bc) | (mc_nxt & ~ff_nxt & hash_tbl[hidx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_lo   <= '0;
      sta_hi   <= '0;
      hash_tbl <= '0;
      rej_bc   <= 1'b0;
      promisc  <= 1'b0;
    end else if (cfg_wr) begin
      case (cfg_ofs)
        OFS_MODE: begin
          rej_bc  <= cfg_wdata[3];
          promisc <= cfg_wdata[5];
        end
        OFS_STA0: sta_lo          <= cfg_wdata[31:0];
        OFS_STA1: sta_hi          <= cfg_wdata[15:0];
        OFS_HSH0: hash_tbl[31:0]  <= cfg_wdata[31:0];
        OFS_HSH1: hash_tbl[63:32] <= cfg_wdata[31:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      crc    <= '1;
      sta_eq <= 1'b1;
      all_ff <= 1'b1;
      mcast  <= 1'b0;
    end else if (rx_sof || take) begin
      cnt    <= cnt_cur + CNT_W'(take);
      crc    <= take ? crc_nxt : crc_cur;
      sta_eq <= take ? eq_nxt  : eq_cur;
      all_ff <= take ? ff_nxt  : ff_cur;
      mcast  <= take ? mc_nxt  : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_vld    <= 1'b0;
      flt_accept <= 1'b0;
    end else if (last) begin
      flt_vld    <= 1'b1;
      flt_accept <= verdict;
    end else if (rx_sof) begin
      flt_vld    <= 1'b0;
      flt_accept <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_sof,
  input logic rx_vld,
  input logic flt_vld,
  input logic flt_accept,
  input logic promisc
);

  logic [2:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                        seen <= '0;
    else if (rx_sof)                   seen <= rx_vld ? 3'd1 : 3'd0;
    else if (rx_vld && seen < 3'd6)    seen <= seen + 3'd1;
  end

  a_r8_strobe_after_sixth: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && !rx_sof && seen == 3'd5) |=> flt_vld);

  a_r8_no_early_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_vld) |-> $past(rx_vld && !rx_sof && seen == 3'd5));

  a_r8_decision_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_vld && !rx_sof) |=> (flt_vld && $stable(flt_accept)));

  a_r9_sof_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sof |=> !flt_vld);

  a_r4_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && !rx_sof && seen == 3'd5 && promisc) |=> flt_accept);

  a_r1_accept_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    flt_accept |-> flt_vld);

endmodule

bind rx_addr_filter rx_addr_filter_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_sof     (rx_sof),
  .rx_vld     (rx_vld),
  .flt_vld    (flt_vld),
  .flt_accept (flt_accept),
  .promisc    (promisc)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_ofs = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rx_sof = 1'b0;
  logic        rx_vld = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        flt_vld, flt_accept;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ofs(cfg_ofs), .cfg_wdata(cfg_wdata),
    .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .flt_vld(flt_vld), .flt_accept(flt_accept)
  );

  localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC_A  = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MC_B  = 48'h01_80_C2_00_00_01;
  localparam logic [47:0] MC_C  = 48'h33_33_00_00_00_FB;

  localparam int NVEC = 8;
  localparam logic [47:0] VEC [NVEC] = '{
    STA, BCAST, MC_A, MC_B, MC_C,
    48'h02_11_22_33_44_54,
    48'h00_00_00_00_00_00,
    48'h0A_0B_0C_0D_0E_0F
  };

  logic [7:0]  mode_m = '0;
  logic [47:0] sta_m  = '0;
  logic [63:0] hash_m = '0;

  function automatic logic [5:0] ref_idx(input logic [47:0] d);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] by;
      by = d[47-8*k -: 8];
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[31] ^ by[b];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] d);
    logic bc, mc;
    bc = (d == BCAST);
    mc = d[40];
    if (mode_m[5])                      return 1'b1;
    if (d == sta_m)                     return 1'b1;
    if (bc)                             return !mode_m[3];
    if (mc)                             return hash_m[ref_idx(d)];
    return 1'b0;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [31:0] dat);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ofs = ofs; cfg_wdata = dat;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (ofs == 8'h00) mode_m = dat[7:0];
    if (ofs == 8'h40) sta_m[31:0] = dat;
    if (ofs == 8'h44) sta_m[47:32] = dat[15:0];
    if (ofs == 8'h48) hash_m[31:0] = dat;
    if (ofs == 8'h4C) hash_m[63:32] = dat;
  endtask

  task automatic set_hash(input logic [63:0] h);
    wr(8'h48, h[31:0]);
    wr(8'h4C, h[63:32]);
  endtask

  task automatic send(input logic [47:0] d, input bit sof_on_first);
    @(negedge clk);
    if (!sof_on_first) begin
      rx_sof = 1'b1;
      @(negedge clk);
      rx_sof = 1'b0;
    end
    for (int k = 0; k < 6; k++) begin
      rx_sof  = sof_on_first && (k == 0);
      rx_vld  = 1'b1;
      rx_byte = d[47-8*k -: 8];
      if (k < 5) @(negedge clk);
    end
  endtask

  task automatic finish_send();
    @(negedge clk);
    rx_vld = 1'b0;
    rx_sof = 1'b0;
  endtask

  task automatic frame(input logic [47:0] d, input string req, input logic exp);
    send(d, 1'b0);
    finish_send();
    chk({req, " strobe"}, flt_vld, 1'b1);
    chk(req, flt_accept, exp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] ia;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset strobe", flt_vld, 1'b0);
    chk("R1 reset accept", flt_accept, 1'b0);
    frame(MC_A, "R1 empty hash rejects multicast", 1'b0);
    frame(BCAST, "R1 broadcast allowed by default", 1'b1);

    wr(8'h40, STA[31:0]);
    wr(8'h44, {16'h0, STA[47:32]});
    ia = ref_idx(MC_A);
    hash_m = '0;
    hash_m[ia] = 1'b1;
    set_hash(hash_m);
    for (int v = 0; v < NVEC; v++) begin
      frame(VEC[v], "R2/R3/R5/R7 table", ref_accept(VEC[v]));
    end
    frame(STA, "R2 station match", 1'b1);
    frame(48'h0A_0B_0C_0D_0E_0F, "R7 foreign unicast", 1'b0);
    frame(MC_A, "R5 hashed multicast", 1'b1);

    hash_m = '0;
    hash_m[{~ia[5], ia[4:0]}] = 1'b1;
    set_hash(hash_m);
    frame(MC_A, "R5 wrong word selected", ref_accept(MC_A));

    set_hash({64{1'b1}});
    frame(MC_B, "R6 full hash multicast B", 1'b1);
    frame(MC_C, "R6 full hash multicast C", 1'b1);
    wr(8'h00, 32'h0000_0008);
    frame(BCAST, "R3 broadcast rejected", 1'b0);
    frame(BCAST, "R6 full hash ignores broadcast", 1'b0);
    set_hash('0);
    wr(8'h00, 32'h0000_0000);
    frame(BCAST, "R6 empty hash broadcast", 1'b1);

    wr(8'h00, 32'h0000_0028);
    frame(48'h0A_0B_0C_0D_0E_0F, "R4 promisc unicast", 1'b1);
    frame(BCAST, "R4 promisc over reject", 1'b1);
    frame(MC_B, "R4 promisc multicast", 1'b1);
    wr(8'h00, 32'h0000_0000);

    send(STA, 1'b0);
    #1 chk("R8 no strobe at sixth byte", flt_vld, 1'b0);
    @(negedge clk);
    rx_byte = 8'hFF;
    chk("R8 strobe one clock later", flt_vld, 1'b1);
    chk("R8 accept one clock later", flt_accept, 1'b1);
    @(negedge clk);
    rx_byte = 8'h00;
    @(negedge clk);
    rx_vld = 1'b0;
    chk("R8 trailing bytes ignored strobe", flt_vld, 1'b1);
    chk("R8 trailing bytes ignored accept", flt_accept, 1'b1);
    rx_sof = 1'b1;
    @(negedge clk);
    rx_sof = 1'b0;
    chk("R9 sof clears strobe", flt_vld, 1'b0);

    send(STA, 1'b1);
    finish_send();
    chk("R9 byte with sof is byte 0 strobe", flt_vld, 1'b1);
    chk("R9 byte with sof is byte 0", flt_accept, 1'b1);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule